// File: doc/BRIEF.md
# Rectangle Fill Raster Engine

This block fills axis-aligned rectangles in a small on-chip pixel store. Software programs a draw-operation code, a foreground colour and a raster-operation code, then writes the rectangle's top row, left column, height and width through a register write port. The width write launches the fill. The engine then reads every covered pixel, combines the old value with the foreground colour and writes the result back. It goes left to right along a row and moves down one row when the row is done.

Pixel addresses are linear word addresses with a fixed row pitch of 2048 words. The store holds the low address bits only, so rows beyond its depth fold back onto earlier rows. A host port reads and writes the store directly while the engine is idle. A busy output covers the whole fill. While it is high, register writes are held off through a ready signal and are not lost.

Top module: `rect_fill_engine`

## Requirements
- R1: A width write starts a fill only when the draw-operation register holds 0x08. Any other code (0x00 to 0x0b included) leaves busy low and writes no pixel.
- R2: Register indices are 0 draw operation (bits 7:0), 1 top row, 2 left column, 3 height, 4 width, 5 foreground colour (all 32 bits kept; red 7:0, green 15:8, blue 23:16), 6 raster operation (bits 7:0). Index 7 is ignored. Software writes the width last, and that write launches the fill.
- R3: The pixel at row r and column c of a rectangle with origin (y, x) is stored at word ((y + r) * 2048 + x + c) modulo 4096.
- R4: Raster code 0x83 stores the foreground, 0x85 keeps the old pixel, 0x86 stores foreground XOR old. Any other code keeps the old pixel.
- R5: The raster-operation register resets to 0x83 and keeps its value across fills until it is rewritten.
- R6: Busy rises on the clock edge that accepts a launching width write. It stays high for exactly height*width+1 cycles and then falls.
- R7: A fill with zero height or zero width leaves busy low and writes no pixel.
- R8: cmd_ready is low while busy. A register write offered during a fill waits and takes effect once the fill ends.
- R9: A host read returns data with host_rvalid one cycle later. Host reads and writes presented while busy are ignored.
- R10: When two successive pixels of a fill fall on the same memory word, the second one is combined with the result of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Register write request |
| cmd_ready | output | 1 | Register write accepted when high with cmd_valid |
| cmd_idx | input | 3 | Register index |
| cmd_data | input | 32 | Register write data |
| busy | output | 1 | Fill in progress |
| host_rd_en | input | 1 | Host read request |
| host_wr_en | input | 1 | Host write request |
| host_addr | input | 12 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| host_rvalid | output | 1 | host_rdata valid |

## Verification
The hardest case to reach from the ports is a read-modify-write whose old value is still in flight. This happens when one pixel reads the word that the previous pixel is writing in the same cycle. It only occurs when the last pixel of a row and the first pixel of the next row fold onto the same word. The stimulus reaches it with a two-row XOR fill whose width is one more than the row pitch, so that word is toggled twice in back-to-back cycles and must end unchanged. Full readbacks of the store against a bench model catch any wrong address, fold or combination.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RI_OPCODE = 3'd0,
    RI_ORG_Y  = 3'd1,
    RI_ORG_X  = 3'd2,
    RI_HEIGHT = 3'd3,
    RI_WIDTH  = 3'd4,
    RI_COLOR  = 3'd5,
    RI_ROP    = 3'd6
  } reg_idx_e;

  localparam logic [7:0] OPC_RECT = 8'h08;
  localparam logic [7:0] ROP_SRC  = 8'h83;
  localparam logic [7:0] ROP_DST  = 8'h85;
  localparam logic [7:0] ROP_XOR  = 8'h86;
endpackage

// File: rtl/rf_pixel_mem.sv
module rf_pixel_mem #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rf_rop_unit.sv
module rf_rop_unit import rf_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic [7:0]    rop,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  output logic [DW-1:0] result
);
  localparam int unsigned LANES = DW / 8;

  logic sel_src, sel_xor;
  assign sel_src = (rop == ROP_SRC);
  assign sel_xor = (rop == ROP_XOR);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] s_b, d_b;
    assign s_b = src[g*8 +: 8];
    assign d_b = dst[g*8 +: 8];
    always_comb begin
      if (sel_src)      result[g*8 +: 8] = s_b;
      else if (sel_xor) result[g*8 +: 8] = s_b ^ d_b;
      else              result[g*8 +: 8] = d_b;
    end
  end
endmodule

// File: rtl/rf_regfile.sv
module rf_regfile import rf_pkg::*; #(
  parameter int unsigned COORD_W = 11,
  parameter int unsigned DIM_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_fire,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [31:0]          wr_data,
  output logic [7:0]           opcode_q,
  output logic [COORD_W-1:0]   org_y_q,
  output logic [COORD_W-1:0]   org_x_q,
  output logic [DIM_W-1:0]     height_q,
  output logic [31:0]          color_q,
  output logic [7:0]           rop_q,
  output logic                 launch,
  output logic [DIM_W-1:0]     launch_width
);
  logic hit_width;
  assign hit_width    = wr_fire && (wr_idx == RI_WIDTH);
  assign launch_width = wr_data[DIM_W-1:0];
  assign launch       = hit_width && (opcode_q == OPC_RECT) &&
                        (height_q != '0) && (launch_width != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_q <= '0;
      org_y_q  <= '0;
      org_x_q  <= '0;
      height_q <= '0;
      color_q  <= '0;
      rop_q    <= ROP_SRC;
    end else if (wr_fire) begin
      case (wr_idx)
        RI_OPCODE: opcode_q <= wr_data[7:0];
        RI_ORG_Y:  org_y_q  <= wr_data[COORD_W-1:0];
        RI_ORG_X:  org_x_q  <= wr_data[COORD_W-1:0];
        RI_HEIGHT: height_q <= wr_data[DIM_W-1:0];
        RI_COLOR:  color_q  <= wr_data;
        RI_ROP:    rop_q    <= wr_data[7:0];
        default:   ;
      endcase
    end
  end

  // R5: raster operation only changes through its own register write
  p_rop_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_fire && wr_idx == RI_ROP) |=> $stable(rop_q));

  // R8: colour cannot change without an accepted write
  p_color_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(color_q));
endmodule

// File: rtl/rf_walker.sv
module rf_walker #(
  parameter int unsigned COORD_W    = 11,
  parameter int unsigned DIM_W      = 12,
  parameter int unsigned PITCH_LOG2 = 11,
  parameter int unsigned MEM_AW     = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic [COORD_W-1:0] org_y,
  input  logic [COORD_W-1:0] org_x,
  input  logic [DIM_W-1:0]   height,
  input  logic [DIM_W-1:0]   width,
  output logic               issue_valid,
  output logic [MEM_AW-1:0]  issue_addr,
  output logic               issue_last
);
  logic               active_q;
  logic [DIM_W-1:0]   row_q, col_q, h_q, w_q;
  logic [COORD_W-1:0] y_q, x_q;
  logic               row_end, col_end;
  logic [MEM_AW-1:0]  row_lin, col_lin;

  assign row_end     = (row_q == h_q - DIM_W'(1));
  assign col_end     = (col_q == w_q - DIM_W'(1));
  assign issue_valid = active_q;
  assign issue_last  = active_q && row_end && col_end;

  // address arithmetic kept modulo the store depth
  assign row_lin    = (MEM_AW'(y_q) + MEM_AW'(row_q)) << PITCH_LOG2;
  assign col_lin    = MEM_AW'(x_q) + MEM_AW'(col_q);
  assign issue_addr = row_lin + col_lin;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      h_q      <= '0;
      w_q      <= '0;
      y_q      <= '0;
      x_q      <= '0;
    end else if (launch && !active_q) begin
      active_q <= 1'b1;
      row_q    <= '0;
      col_q    <= '0;
      h_q      <= height;
      w_q      <= width;
      y_q      <= org_y;
      x_q      <= org_x;
    end else if (active_q) begin
      if (issue_last) begin
        active_q <= 1'b0;
      end else if (col_end) begin
        col_q <= '0;
        row_q <= row_q + DIM_W'(1);
      end else begin
        col_q <= col_q + DIM_W'(1);
      end
    end
  end

  p_bounds_r6: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (row_q < h_q) && (col_q < w_q));

  p_step_in_row_r6: assert property (@(posedge clk) disable iff (rst)
    active_q && !col_end |=> active_q && col_q == $past(col_q) + DIM_W'(1) &&
                             row_q == $past(row_q));

  p_step_next_row_r6: assert property (@(posedge clk) disable iff (rst)
    active_q && col_end && !row_end |=> active_q && col_q == '0 &&
                                        row_q == $past(row_q) + DIM_W'(1));

  p_no_relaunch_r8: assert property (@(posedge clk) disable iff (rst)
    active_q |-> !launch);
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine import rf_pkg::*; #(
  parameter int unsigned COORD_W    = 11,
  parameter int unsigned DIM_W      = 12,
  parameter int unsigned PITCH_LOG2 = 11,
  parameter int unsigned MEM_AW     = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [REG_IDX_W-1:0] cmd_idx,
  input  logic [31:0]          cmd_data,
  output logic                 busy,
  input  logic                 host_rd_en,
  input  logic                 host_wr_en,
  input  logic [MEM_AW-1:0]    host_addr,
  input  logic [31:0]          host_wdata,
  output logic [31:0]          host_rdata,
  output logic                 host_rvalid
);
  localparam int unsigned DW = 32;

  logic               busy_q;
  logic               cmd_fire;
  logic [7:0]         cfg_opcode, cfg_rop;
  logic [COORD_W-1:0] cfg_y, cfg_x;
  logic [DIM_W-1:0]   cfg_h, launch_w;
  logic [DW-1:0]      cfg_color;
  logic               launch;

  logic               iss_valid, iss_last;
  logic [MEM_AW-1:0]  iss_addr;

  logic               st_valid_q;
  logic [MEM_AW-1:0]  st_addr_q;
  logic               fwd_q;
  logic [DW-1:0]      fwd_data_q;
  logic [DW-1:0]      old_pix, new_pix;

  logic               m_we, m_re;
  logic [MEM_AW-1:0]  m_waddr, m_raddr;
  logic [DW-1:0]      m_wdata, m_rdata;
  logic               host_ok;
  logic               rvalid_q;

  assign cmd_ready = !busy_q;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign busy      = busy_q;
  assign host_ok   = !busy_q;

  rf_regfile #(.COORD_W(COORD_W), .DIM_W(DIM_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_fire      (cmd_fire),
    .wr_idx       (cmd_idx),
    .wr_data      (cmd_data),
    .opcode_q     (cfg_opcode),
    .org_y_q      (cfg_y),
    .org_x_q      (cfg_x),
    .height_q     (cfg_h),
    .color_q      (cfg_color),
    .rop_q        (cfg_rop),
    .launch       (launch),
    .launch_width (launch_w)
  );

  rf_walker #(.COORD_W(COORD_W), .DIM_W(DIM_W), .PITCH_LOG2(PITCH_LOG2),
              .MEM_AW(MEM_AW)) u_walk (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .org_y       (cfg_y),
    .org_x       (cfg_x),
    .height      (cfg_h),
    .width       (launch_w),
    .issue_valid (iss_valid),
    .issue_addr  (iss_addr),
    .issue_last  (iss_last)
  );

  // read side: engine owns the port while it issues, host otherwise
  assign m_re    = iss_valid || (host_rd_en && host_ok);
  assign m_raddr = iss_valid ? iss_addr : host_addr;

  // the old pixel comes from the store unless the word was written in the read cycle
  assign old_pix = fwd_q ? fwd_data_q : m_rdata;

  rf_rop_unit #(.DW(DW)) u_rop (
    .rop    (cfg_rop),
    .src    (cfg_color),
    .dst    (old_pix),
    .result (new_pix)
  );

  assign m_we    = st_valid_q || (host_wr_en && host_ok);
  assign m_waddr = st_valid_q ? st_addr_q : host_addr;
  assign m_wdata = st_valid_q ? new_pix : host_wdata;

  rf_pixel_mem #(.AW(MEM_AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (m_we),
    .waddr (m_waddr),
    .wdata (m_wdata),
    .re    (m_re),
    .raddr (m_raddr),
    .rdata (m_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      st_valid_q <= 1'b0;
      st_addr_q  <= '0;
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      busy_q     <= launch || iss_valid;
      st_valid_q <= iss_valid;
      st_addr_q  <= iss_addr;
      fwd_q      <= iss_valid && st_valid_q && (iss_addr == st_addr_q);
      fwd_data_q <= new_pix;
      rvalid_q   <= host_rd_en && host_ok;
    end
  end

  assign host_rdata  = m_rdata;
  assign host_rvalid = rvalid_q;

  // R6: every engine write lies inside the busy window
  p_write_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    st_valid_q |-> busy_q);

  // R6: the final issued pixel is written in the following cycle
  p_last_then_write_r6: assert property (@(posedge clk) disable iff (rst)
    iss_last |=> st_valid_q && busy_q);

  // R7: zero width never starts a fill
  p_zero_dim_idle_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_fire && cmd_idx == RI_WIDTH && cmd_data[DIM_W-1:0] == '0 |=> !busy_q);

  // R1: width write under a non-rectangle code stays idle
  p_bad_opcode_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_fire && cmd_idx == RI_WIDTH && cfg_opcode != OPC_RECT |=> !busy_q);

  // R9: host reads during a fill get no response
  p_host_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !host_rvalid);
endmodule

// File: tb/rect_fill_engine_test.sv
module rect_fill_engine_test;
  localparam int DEPTH = 4096;
  localparam int PITCH = 2048;
  localparam logic [2:0] I_OP = 3'd0, I_Y = 3'd1, I_X = 3'd2, I_H = 3'd3,
                         I_W = 3'd4, I_FG = 3'd5, I_ROP = 3'd6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_idx = '0;
  logic [31:0] cmd_data = '0;
  logic        busy;
  logic        host_rd_en = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;

  always #5 clk = ~clk;

  rect_fill_engine uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .busy(busy),
    .host_rd_en(host_rd_en), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0] model [DEPTH];
  logic [31:0] exp_q [$];
  string rb_tag = "R9";
  logic [7:0]  cur_rop = 8'h83;
  logic [31:0] cur_fg = 32'h0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rop_apply(input logic [7:0] r,
                                            input logic [31:0] s, input logic [31:0] d);
    if (r == 8'h83) return s;
    if (r == 8'h86) return s ^ d;
    return d;
  endfunction

  // scoreboard monitor: every read response is compared with the queued value
  always @(negedge clk) begin
    if (host_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R9", "unexpected read response", host_rdata, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(host_rdata === e, rb_tag, "pixel readback", host_rdata, e);
      end
    end
  end

  task automatic reg_write(input logic [2:0] idx, input logic [31:0] d, output int waited);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_idx = idx; cmd_data = d; waited = 0;
    @(negedge clk);
    while (!cmd_ready) begin waited++; @(negedge clk); end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic set_rop(input logic [7:0] r);
    int wt;
    reg_write(I_ROP, {24'h0, r}, wt);
    cur_rop = r;
  endtask

  task automatic set_fg(input logic [31:0] c);
    int wt;
    reg_write(I_FG, c, wt);
    cur_fg = c;
  endtask

  task automatic model_fill(input int y, input int x, input int h, input int w);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        int a;
        a = ((y + r) * PITCH + x + c) % DEPTH;
        model[a] = rop_apply(cur_rop, cur_fg, model[a]);
      end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic launch(input logic [7:0] op, input int y, input int x,
                        input int h, input int w);
    int wt;
    reg_write(I_OP, {24'h0, op}, wt);
    reg_write(I_Y, y, wt);
    reg_write(I_X, x, wt);
    reg_write(I_H, h, wt);
    reg_write(I_W, w, wt);
  endtask

  task automatic fill(input logic [7:0] op, input int y, input int x,
                      input int h, input int w, input string req);
    int cnt;
    int exp;
    launch(op, y, x, h, w);
    cnt = 0;
    @(negedge clk);
    while (busy) begin cnt++; @(negedge clk); end
    exp = (op == 8'h08 && h != 0 && w != 0) ? h * w + 1 : 0;
    check(cnt == exp, req, "busy cycles", cnt, exp);
    if (exp != 0) model_fill(y, x, h, w);
  endtask

  task automatic read_all(input string tag);
    rb_tag = tag;
    for (int a = 0; a < DEPTH; a++) begin
      @(posedge clk); #1;
      host_rd_en = 1'b1; host_addr = a[11:0];
      exp_q.push_back(model[a]);
    end
    @(posedge clk); #1;
    host_rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "responses outstanding", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int wt;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8", "ready after reset", cmd_ready, 1);
    check(busy == 1'b0, "R6", "busy after reset", busy, 0);
    check(host_rvalid == 1'b0, "R9", "rvalid after reset", host_rvalid, 0);

    // preload the store through the host port
    for (int a = 0; a < DEPTH; a++) model[a] = 32'h5A000000 ^ (a * 32'h00010203);
    for (int a = 0; a < DEPTH; a++) begin
      @(posedge clk); #1;
      host_wr_en = 1'b1; host_addr = a[11:0]; host_wdata = model[a];
    end
    @(posedge clk); #1;
    host_wr_en = 1'b0;
    read_all("R9");

    // R5 default raster operation stores the colour; R2 colour kept whole
    set_fg(32'hA1C0FFEE);
    fill(8'h08, 0, 5, 2, 3, "R5");
    read_all("R3");

    // R4 XOR, then R5 persistence without rewriting the raster register
    set_rop(8'h86);
    set_fg(32'h0F0F0F0F);
    fill(8'h08, 1, 3, 1, 4, "R4");
    fill(8'h08, 0, 6, 2, 2, "R5");
    read_all("R4");

    // R4 keep-old and unknown codes change nothing but still walk
    set_rop(8'h85);
    fill(8'h08, 0, 0, 2, 10, "R4");
    set_rop(8'h42);
    fill(8'h08, 1, 20, 1, 7, "R4");
    read_all("R4");

    // R1 other draw codes, R7 zero sizes
    set_rop(8'h83);
    set_fg(32'h00112233);
    fill(8'h09, 0, 0, 2, 5, "R1");
    fill(8'h00, 0, 0, 2, 5, "R1");
    fill(8'h0b, 1, 1, 1, 1, "R1");
    fill(8'h08, 0, 40, 0, 5, "R7");
    fill(8'h08, 0, 40, 3, 0, "R7");
    // R2 index 7 is ignored: colour stays, next fill uses it
    reg_write(3'd7, 32'hFFFFFFFF, wt);
    fill(8'h08, 1, 50, 1, 2, "R2");
    read_all("R1");

    // R3 row folding and column overflow into the next row
    set_fg(32'h00123456);
    fill(8'h08, 3, 2040, 1, 16, "R3");
    read_all("R3");

    // R10 last pixel of row 0 and first of row 1 share one word
    set_rop(8'h86);
    set_fg(32'h00FF00FF);
    fill(8'h08, 0, 7, 2, 2049, "R10");
    read_all("R10");

    // R8 register write during a fill is stalled, then applied
    set_rop(8'h83);
    set_fg(32'h00ABCDEF);
    launch(8'h08, 1, 100, 1, 20);
    model_fill(1, 100, 1, 20);
    reg_write(I_FG, 32'h00445566, wt);
    check(wt == 20, "R8", "stall cycles", wt, 20);
    cur_fg = 32'h00445566;
    fill(8'h08, 1, 100, 1, 20, "R8");
    read_all("R8");

    // R9 host traffic during a fill is ignored
    launch(8'h08, 0, 1000, 1, 30);
    model_fill(0, 1000, 1, 30);
    host_wr_en = 1'b1; host_addr = 12'd4000; host_wdata = 32'hDEADBEEF;
    @(posedge clk); #1;
    host_wr_en = 1'b0; host_rd_en = 1'b1;
    @(posedge clk); #1;
    host_rd_en = 1'b0;
    @(negedge clk);
    check(host_rvalid == 1'b0, "R9", "read while busy", host_rvalid, 0);
    check(busy == 1'b1, "R6", "busy during fill", busy, 1);
    wait_idle();
    read_all("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule